// File: doc/BRIEF.md
# Page-Split Flash Writer with Read-Back Verify

This block writes a byte stream into a page-organised serial flash by way of the device's internal page buffer. A request gives a linear byte address and a length. The block divides the request into pieces that never cross a page boundary. For each piece it emits up to three command frames toward a byte serializer: an optional page load into the buffer, a program frame that carries the new bytes, and a compare of the buffer against the array. After each frame it asks an external poller to wait until the device is ready. It then reads bit 6 of the returned status after the compare.

Payload bytes arrive on a valid/ready stream. During the data phase of a program frame that stream passes straight through to the serializer, so back-pressure on either side stalls the other. Chip select stays asserted from the opcode to the last byte of each frame. Completion is a one-cycle `done` pulse with two error flags and the count of bytes that have been committed.

States: `ST_IDLE` (accept request) → `ST_SETUP` (range and zero-length check) → `ST_PLAN` (size the next piece) → `ST_LOAD_CMD` → `ST_LOAD_WAIT` (partial pieces only) → `ST_PROG_HDR` → `ST_PROG_DATA` → `ST_PROG_WAIT` → `ST_CMP_CMD` → `ST_CMP_WAIT`. From `ST_CMP_WAIT` the block returns to `ST_PLAN` for the next piece, or goes to `ST_DONE` at the end or on a mismatch. `ST_SETUP` goes straight to `ST_DONE` for an empty or out-of-range request, and `ST_DONE` returns to `ST_IDLE`.

Top module: `pp_page_writer`

## Requirements
- R1: A request whose start plus length exceeds PAGE_BYTES×NUM_PAGES finishes with `fail_range`=1 and `bytes_written`=0. It emits no frame and consumes no stream byte.
- R2: A zero-length request finishes with both fail flags low and `bytes_written`=0. It emits no frame.
- R3: The first piece is min(PAGE_BYTES − start offset, length) bytes. Every later piece is a full page, except the last, which holds what remains. The offset is start mod PAGE_BYTES and the page is start div PAGE_BYTES.
- R4: A piece shorter than PAGE_BYTES is preceded by a 4-byte load frame: 0x53, bits [23:16] and [15:8] of (page << PAGE_SHIFT), then 0x00. A full-page piece has no load frame.
- R5: Each piece has a program frame: 0x82, then the 24-bit address ((page << PAGE_SHIFT) | offset) most significant byte first, then the piece's stream bytes in order. `cs_n` stays low for the whole frame, and stream bytes are taken only inside it.
- R6: Each piece ends with a 4-byte compare frame: 0x60, page address bits [23:16] and [15:8], then 0x00.
- R7: After every frame `cs_n` goes high and `poll_req` is raised. No byte is offered until `poll_done` arrives.
- R8: If `poll_status` bit 6 is 1 when the compare wait completes, the request ends with `fail_verify`=1 and no further frames. The other status bits have no effect.
- R9: `bytes_written` is cleared when a request is accepted. It grows by a piece's length only when that piece's compare passes.
- R10: `req_ready` is high only when idle. `done` is a single-cycle pulse, after which the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | BA_W | Linear start byte address |
| req_len | input | BA_W | Byte count |
| din_valid | input | 1 | Payload byte valid |
| din_ready | output | 1 | Payload byte taken |
| din_data | input | 8 | Payload byte |
| cs_n | output | 1 | Chip select, low during a frame |
| tx_valid | output | 1 | Byte offered to serializer |
| tx_ready | input | 1 | Serializer takes byte |
| tx_data | output | 8 | Byte to serializer |
| poll_req | output | 1 | Wait-for-ready request |
| poll_done | input | 1 | Device ready, status valid |
| poll_status | input | 8 | Device status byte |
| done | output | 1 | Request complete pulse |
| fail_range | output | 1 | Request exceeded device |
| fail_verify | output | 1 | Compare mismatch |
| bytes_written | output | BA_W | Committed byte count |

## Verification
The compare verdict and the end-of-request decision both resolve on the same `poll_done` edge in `ST_CMP_WAIT`. A mismatch on the final piece therefore competes with normal completion. The bench forces this case by injecting bit 6 on the compare of a single-page request and on the last piece of random requests. It then checks that `fail_verify` is set and that `bytes_written` excludes that piece. It also randomises `tx_ready` and `din_valid` together, so the last data byte and a stall on either side often fall in one cycle. The emitted byte sequence is compared against a bench model of the frames.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PLAN,
        ST_LOAD_CMD,
        ST_LOAD_WAIT,
        ST_PROG_HDR,
        ST_PROG_DATA,
        ST_PROG_WAIT,
        ST_CMP_CMD,
        ST_CMP_WAIT,
        ST_DONE
    } pp_state_e;

    localparam logic [7:0] OPC_LOAD = 8'h53;
    localparam logic [7:0] OPC_PROG = 8'h82;
    localparam logic [7:0] OPC_CMP  = 8'h60;

    localparam int MISMATCH_BIT = 6;

endpackage

// File: rtl/pp_piece_calc.sv
module pp_piece_calc #(
    parameter int PAGE_BYTES = 264,
    parameter int BA_W       = 18,
    parameter int OFF_W      = 9
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [BA_W-1:0]  remaining,
    output logic [BA_W-1:0]  piece,
    output logic             partial
);
    localparam logic [BA_W-1:0] FULL = BA_W'(PAGE_BYTES);

    logic [BA_W-1:0] room;

    always_comb begin
        room    = FULL - BA_W'(offset);
        piece   = (remaining < room) ? remaining : room;
        partial = (piece != FULL);
    end
endmodule

// File: rtl/pp_frame_hdr.sv
module pp_frame_hdr #(
    parameter int PG_W       = 9,
    parameter int OFF_W      = 9,
    parameter int PAGE_SHIFT = 9
) (
    input  logic [7:0]       opcode,
    input  logic [PG_W-1:0]  page,
    input  logic [OFF_W-1:0] offset,
    input  logic             with_offset,
    input  logic [1:0]       idx,
    output logic [7:0]       hdr_byte
);
    logic [23:0] dev_addr;

    always_comb begin
        dev_addr = 24'(page) << PAGE_SHIFT;
        if (with_offset) begin
            dev_addr = dev_addr | 24'(offset);
        end
        unique case (idx)
            2'd0:    hdr_byte = opcode;
            2'd1:    hdr_byte = dev_addr[23:16];
            2'd2:    hdr_byte = dev_addr[15:8];
            default: hdr_byte = with_offset ? dev_addr[7:0] : 8'h00;
        endcase
    end
endmodule

// File: rtl/pp_page_writer.sv
module pp_page_writer
    import pp_pkg::*;
#(
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int NUM_PAGES  = 512,
    localparam int DEV_BYTES = PAGE_BYTES * NUM_PAGES,
    localparam int BA_W      = $clog2(DEV_BYTES + 1),
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [BA_W-1:0] req_addr,
    input  logic [BA_W-1:0] req_len,
    input  logic            din_valid,
    output logic            din_ready,
    input  logic [7:0]      din_data,
    output logic            cs_n,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [7:0]      tx_data,
    output logic            poll_req,
    input  logic            poll_done,
    input  logic [7:0]      poll_status,
    output logic            done,
    output logic            fail_range,
    output logic            fail_verify,
    output logic [BA_W-1:0] bytes_written
);
    localparam logic [BA_W-1:0] PAGE_W = BA_W'(PAGE_BYTES);
    localparam logic [BA_W:0]   DEV_W  = (BA_W + 1)'(DEV_BYTES);

    pp_state_e state, nxt;

    logic [BA_W-1:0]  start_q, len_q, remain_q, piece_q, data_cnt, bw_q;
    logic [PG_W-1:0]  page_q;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       hdr_idx;
    logic             fail_range_q, fail_verify_q;

    logic [BA_W:0]    end_w;
    logic             over_w;
    logic [BA_W-1:0]  piece_w;
    logic             partial_w;
    logic [7:0]       hdr_opc;
    logic             hdr_with_off;
    logic [7:0]       hdr_byte;
    logic             last_byte;
    logic             mismatch;
    logic             unused_status;

    assign end_w         = {1'b0, start_q} + {1'b0, len_q};
    assign over_w        = end_w > DEV_W;
    assign last_byte     = (data_cnt == piece_q - BA_W'(1));
    assign mismatch      = poll_status[MISMATCH_BIT];
    assign unused_status = ^{poll_status[7], poll_status[5:0]};

    pp_piece_calc #(
        .PAGE_BYTES (PAGE_BYTES),
        .BA_W       (BA_W),
        .OFF_W      (OFF_W)
    ) u_piece (
        .offset    (off_q),
        .remaining (remain_q),
        .piece     (piece_w),
        .partial   (partial_w)
    );

    pp_frame_hdr #(
        .PG_W       (PG_W),
        .OFF_W      (OFF_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_hdr (
        .opcode      (hdr_opc),
        .page        (page_q),
        .offset      (off_q),
        .with_offset (hdr_with_off),
        .idx         (hdr_idx),
        .hdr_byte    (hdr_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) nxt = ST_SETUP;
            ST_SETUP:     nxt = (len_q == '0 || over_w) ? ST_DONE : ST_PLAN;
            ST_PLAN:      nxt = partial_w ? ST_LOAD_CMD : ST_PROG_HDR;
            ST_LOAD_CMD:  if (tx_ready && hdr_idx == 2'd3) nxt = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (poll_done) nxt = ST_PROG_HDR;
            ST_PROG_HDR:  if (tx_ready && hdr_idx == 2'd3) nxt = ST_PROG_DATA;
            ST_PROG_DATA: if (din_valid && tx_ready && last_byte) nxt = ST_PROG_WAIT;
            ST_PROG_WAIT: if (poll_done) nxt = ST_CMP_CMD;
            ST_CMP_CMD:   if (tx_ready && hdr_idx == 2'd3) nxt = ST_CMP_WAIT;
            ST_CMP_WAIT:  if (poll_done)
                              nxt = (mismatch || remain_q == piece_q) ? ST_DONE : ST_PLAN;
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q       <= '0;
            len_q         <= '0;
            remain_q      <= '0;
            piece_q       <= '0;
            data_cnt      <= '0;
            bw_q          <= '0;
            page_q        <= '0;
            off_q         <= '0;
            hdr_idx       <= '0;
            fail_range_q  <= 1'b0;
            fail_verify_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    start_q       <= req_addr;
                    len_q         <= req_len;
                    bw_q          <= '0;
                    fail_range_q  <= 1'b0;
                    fail_verify_q <= 1'b0;
                end
                ST_SETUP: begin
                    if (len_q != '0 && over_w) fail_range_q <= 1'b1;
                    page_q   <= PG_W'(start_q / PAGE_W);
                    off_q    <= OFF_W'(start_q % PAGE_W);
                    remain_q <= len_q;
                end
                ST_PLAN: begin
                    piece_q  <= piece_w;
                    data_cnt <= '0;
                    hdr_idx  <= '0;
                end
                ST_LOAD_CMD, ST_PROG_HDR, ST_CMP_CMD:
                    if (tx_ready) hdr_idx <= hdr_idx + 2'd1;
                ST_PROG_DATA:
                    if (din_valid && tx_ready) data_cnt <= data_cnt + BA_W'(1);
                ST_CMP_WAIT: if (poll_done) begin
                    if (mismatch) begin
                        fail_verify_q <= 1'b1;
                    end else begin
                        bw_q     <= bw_q + piece_q;
                        remain_q <= remain_q - piece_q;
                        page_q   <= page_q + PG_W'(1);
                        off_q    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        din_ready    = 1'b0;
        cs_n         = 1'b1;
        tx_valid     = 1'b0;
        tx_data      = 8'h00;
        poll_req     = 1'b0;
        done         = 1'b0;
        hdr_opc      = OPC_PROG;
        hdr_with_off = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_LOAD_CMD: begin
                cs_n     = 1'b0;
                tx_valid = 1'b1;
                hdr_opc  = OPC_LOAD;
                tx_data  = hdr_byte;
            end
            ST_PROG_HDR: begin
                cs_n         = 1'b0;
                tx_valid     = 1'b1;
                hdr_opc      = OPC_PROG;
                hdr_with_off = 1'b1;
                tx_data      = hdr_byte;
            end
            ST_PROG_DATA: begin
                cs_n      = 1'b0;
                tx_valid  = din_valid;
                din_ready = tx_ready;
                tx_data   = din_data;
            end
            ST_CMP_CMD: begin
                cs_n     = 1'b0;
                tx_valid = 1'b1;
                hdr_opc  = OPC_CMP;
                tx_data  = hdr_byte;
            end
            ST_LOAD_WAIT, ST_PROG_WAIT, ST_CMP_WAIT: poll_req = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign fail_range    = fail_range_q;
    assign fail_verify   = fail_verify_q;
    assign bytes_written = bw_q;

endmodule

// File: rtl/pp_page_writer_chk.sv
module pp_page_writer_chk #(
    parameter int BA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            din_ready,
    input logic            cs_n,
    input logic            tx_valid,
    input logic            poll_req,
    input logic            done,
    input logic            fail_range,
    input logic            fail_verify,
    input logic [BA_W-1:0] bytes_written
);
    AST_WAIT_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> cs_n);                                              // R7
    AST_WAIT_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> !tx_valid);                                         // R7
    AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> !cs_n);                                            // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !poll_req && !done));                     // R10
    AST_RANGE_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail_range) |-> (bytes_written == '0));                 // R1
    AST_COUNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable(bytes_written));                               // R9
    AST_ONE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(fail_range && fail_verify));                          // R8
endmodule

bind pp_page_writer pp_page_writer_chk #(.BA_W(BA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .din_ready     (din_ready),
    .cs_n          (cs_n),
    .tx_valid      (tx_valid),
    .poll_req      (poll_req),
    .done          (done),
    .fail_range    (fail_range),
    .fail_verify   (fail_verify),
    .bytes_written (bytes_written)
);

// File: tb/tb_pp_page_writer.sv
module tb_pp_page_writer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PB  = 12;
    localparam int PS  = 8;
    localparam int NP  = 20;
    localparam int DEV = PB * NP;
    localparam int BW  = $clog2(DEV + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_addr = '0;
    logic [BW-1:0] req_len = '0;
    logic          din_valid;
    logic          din_ready;
    logic [7:0]    din_data;
    logic          cs_n;
    logic          tx_valid;
    logic          tx_ready;
    logic [7:0]    tx_data;
    logic          poll_req;
    logic          poll_done;
    logic [7:0]    poll_status;
    logic          done;
    logic          fail_range;
    logic          fail_verify;
    logic [BW-1:0] bytes_written;

    always #2.5 clk = ~clk;

    pp_page_writer #(.PAGE_BYTES(PB), .PAGE_SHIFT(PS), .NUM_PAGES(NP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .din_valid(din_valid),
        .din_ready(din_ready), .din_data(din_data), .cs_n(cs_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .poll_req(poll_req), .poll_done(poll_done), .poll_status(poll_status),
        .done(done), .fail_range(fail_range), .fail_verify(fail_verify),
        .bytes_written(bytes_written)
    );

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int dq[$];
    int stream_err = 0;
    int frame_byte = 0;
    int last_op = 0;
    int cmp_seen = 0;
    int inject_at = -1;
    int pcnt = 0;
    int pdelay = 1;
    logic prev_cs = 1'b1;
    logic done_seen = 1'b0;
    logic seen_fr, seen_fv;
    int   seen_bw;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Serializer, stream source and status poller model
    initial begin
        tx_ready = 1'b0; din_valid = 1'b0; din_data = 8'h00;
        poll_done = 1'b0; poll_status = 8'h00;
        forever begin
            @(negedge clk);
            tx_ready  = ($urandom % 4) != 0;
            din_valid = (dq.size() > 0) && (($urandom % 4) != 0);
            din_data  = (dq.size() > 0) ? 8'(dq[0]) : 8'h00;
            if (poll_done) begin
                poll_done = 1'b0;
                pcnt = 0;
                pdelay = 1 + int'($urandom % 3);
            end else if (poll_req) begin
                pcnt++;
                if (pcnt >= pdelay) begin
                    poll_done   = 1'b1;
                    poll_status = 8'h80 | (8'($urandom) & 8'h3F) |
                        ((last_op == 8'h60 && cmp_seen - 1 == inject_at) ? 8'h40 : 8'h00);
                end
            end
            #1;
            if (poll_req && tx_valid) stream_err++;
            if (tx_valid && tx_ready) begin
                if (frame_byte == 0) begin
                    last_op = int'(tx_data);
                    if (tx_data == 8'h60) cmp_seen++;
                end
                frame_byte++;
                if (exp_q.size() == 0 || exp_q[0] != int'(tx_data)) stream_err++;
                if (exp_q.size() > 0) void'(exp_q.pop_front());
            end
            if (din_valid && din_ready) void'(dq.pop_front());
            if (!prev_cs && cs_n) begin
                frame_byte = 0;
                if (exp_q.size() == 0 || exp_q[0] != -1) stream_err++;
                if (exp_q.size() > 0) void'(exp_q.pop_front());
            end
            prev_cs = cs_n;
            if (done) begin
                done_seen = 1'b1;
                seen_fr = fail_range;
                seen_fv = fail_verify;
                seen_bw = int'(bytes_written);
            end
        end
    end

    task automatic push_hdr(input int op, input int a);
        exp_q.push_back(op);
        exp_q.push_back((a >> 16) & 255);
        exp_q.push_back((a >> 8) & 255);
        exp_q.push_back(a & 255);
    endtask

    // R3..R6 frame model, R8/R9 outcome model
    task automatic run_req(input int addr, input int len, input int inject, input string name);
        int data[$];
        int exp_bw = 0, consumed = 0, n = 0;
        bit exp_fr = 0, exp_fv = 0;
        for (int i = 0; i < len; i++) data.push_back(int'($urandom % 256));
        exp_q.delete();
        if (len > 0 && addr + len > DEV) begin
            exp_fr = 1;
        end else if (len > 0) begin
            int pg = addr / PB, off = addr % PB, rem = len, k = 0, pos = 0;
            while (rem > 0) begin
                int piece = (PB - off < rem) ? (PB - off) : rem;
                if (piece != PB) begin
                    push_hdr(8'h53, pg << PS); exp_q.push_back(-1);
                end
                push_hdr(8'h82, (pg << PS) | off);
                for (int j = 0; j < piece; j++) exp_q.push_back(data[pos + j]);
                exp_q.push_back(-1);
                push_hdr(8'h60, pg << PS); exp_q.push_back(-1);
                consumed += piece;
                pos += piece;
                if (k == inject) begin exp_fv = 1; break; end
                exp_bw += piece; rem -= piece; pg++; off = 0; k++;
            end
        end
        dq = data;
        inject_at = inject; cmp_seen = 0; stream_err = 0; done_seen = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = BW'(addr); req_len = BW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_seen && n < 4000) begin @(negedge clk); n++; end
        chk(done_seen, {"R10 done reached ", name}, int'(done_seen), 1);
        chk(seen_fr == exp_fr, {"R1 fail_range ", name}, int'(seen_fr), int'(exp_fr));
        chk(seen_fv == exp_fv, {"R8 fail_verify ", name}, int'(seen_fv), int'(exp_fv));
        chk(seen_bw == exp_bw, {"R9 bytes_written ", name}, seen_bw, exp_bw);
        chk(stream_err == 0 && exp_q.size() == 0, {"R3/R4/R5/R6/R7 frames ", name},
            stream_err + exp_q.size(), 0);
        chk(dq.size() == len - consumed, {"R5 stream bytes left ", name}, dq.size(), len - consumed);
        @(negedge clk); #1.5;
        chk(!done && req_ready, {"R10 idle after done ", name}, int'(done), 0);
        dq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        chk(req_ready && cs_n && !poll_req && !done && !tx_valid && bytes_written == '0,
            "R10 reset state", int'(req_ready), 1);
        run_req(0, PB, -1, "full page");            // R4 no load frame
        run_req(5, 30, -1, "offset split");         // R3 pieces 7,12,11
        run_req(0, 0, -1, "zero length");           // R2
        run_req(230, 11, -1, "past end");           // R1
        run_req(DEV - PB, PB, -1, "last page");     // R1 boundary accepted
        run_req(10, 30, 1, "mismatch mid");         // R8 second compare fails
        run_req(24, PB, 0, "mismatch last");        // R8 vs completion same edge
        for (int t = 0; t < 30; t++) begin
            int a = int'($urandom % DEV);
            int sel = int'($urandom % 10);
            int l, inj;
            if (sel == 0) l = 0;
            else if (sel == 1) l = DEV - a + 1 + int'($urandom % 4);
            else begin
                int room = (DEV - a < 40) ? DEV - a : 40;
                l = 1 + int'($urandom % room);
            end
            if (l > 255) l = 255;
            inj = (($urandom % 5) == 0) ? int'($urandom % 3) : -1;
            run_req(a, l, inj, "random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule